// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column addresses of a single SDRAM read or write burst, one address per beat. A controller presents a start column, a 3-bit burst length code and an ordering bit together with a one-cycle start strobe. The block then shows the first column and raises a valid flag. Each advance strobe steps it to the next column in the chosen order. A last-beat flag marks the final column of a fixed-length burst.

Bursts of 2, 4 or 8 beats stay inside the aligned block that holds the start column. They use either linear wrap-around order or interleaved order, where the beat index is XORed into the low column bits. A full-page burst steps through the whole row, wraps from the top column back to column 0, and keeps going until the terminate input ends it. Length codes with no meaning run as a single beat and raise an error flag. The block issues no commands, moves no data and enforces no DRAM timing.

Top module: `burst_col_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows valid_o, last_o and len_err_o at 0.
- R2: A start_i pulse makes valid_o high in the next cycle, with col_o equal to the start column. start_i takes priority over term_i and adv_i.
- R3: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. valid_o drops in the cycle after adv_i is seen on the last beat.
- R4: With ordering bit 0 and a length L of 2, 4 or 8, beat k shows the column whose upper bits equal those of the start column and whose low log2(L) bits equal (start + k) mod L.
- R5: With ordering bit 1 and a length L of 2, 4 or 8, beat k shows the start column XOR k. Only the low log2(L) bits change.
- R6: last_o is high exactly on the cycle that shows the final column of a fixed-length burst, and never while valid_o is low.
- R7: Code 3'b111 with ordering bit 0 is a full-page burst. Beat k shows (start + k) mod 2^COL_W. last_o never rises, and the burst continues past 2^COL_W beats.
- R8: term_i seen while valid_o is high ends the burst in any mode: valid_o is low in the next cycle.
- R9: For length code 3'b000 the ordering bit has no effect on col_o.
- R10: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with ordering bit 1, run a one-beat burst. len_err_o is high while that burst is valid and low otherwise.
- R11: While valid_o is high and none of adv_i, term_i or start_i is asserted, col_o and valid_o hold their values.
- R12: start_i during an active burst abandons it and starts the new burst from beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a burst using the inputs below |
| adv_i | input | 1 | Step to the next beat |
| term_i | input | 1 | End the current burst |
| col_start_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Ordering: 0 linear, 1 interleaved |
| col_o | output | COL_W | Column address for the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Final beat of a fixed-length burst |
| len_err_o | output | 1 | Current burst uses a reserved length code |

## Verification
Linear and interleaved bursts are started from columns that are aligned and from columns that are not. This separates plain wrap-around from XOR ordering, and checks that the upper column bits stay fixed inside each block. Advance strobes come back to back and also with gaps, which exposes a beat counter that moves without an advance. A full-page burst runs for more than a whole row, which shows the wrap to column 0 and the absence of a self-generated last flag. Terminate, restart and reserved-code bursts cover how a burst can end early or be replaced.

// File: rtl/burst_seq_pkg.sv
// Package: shared length-code encodings for the burst column sequencer.
// Assumes a 3-bit length code; values not listed here are reserved.
package burst_seq_pkg;
    localparam int LEN_CODE_W = 3;

    typedef enum logic [LEN_CODE_W-1:0] {
        BLEN_1    = 3'b000,
        BLEN_2    = 3'b001,
        BLEN_4    = 3'b010,
        BLEN_8    = 3'b011,
        BLEN_PAGE = 3'b111
    } blen_code_e;
endpackage

// File: rtl/burst_len_decode.sv
// Module: turns a length code and ordering bit into a low-bit wrap mask,
// a full-page flag and a reserved-code flag.
// Assumes COL_W >= 3. Reserved codes decode as a single beat (mask 0).
module burst_len_decode
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [LEN_CODE_W-1:0] code_i,
    input  logic                  ilv_i,
    output logic [COL_W-1:0]      mask_o,
    output logic                  full_o,
    output logic                  rsvd_o
);
    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

    // Purpose: map each code to its mask; flag anything unsupported.
    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        rsvd_o = 1'b0;
        case (code_i)
            BLEN_1:    mask_o = '0;
            BLEN_2:    mask_o = COL_W'(1);
            BLEN_4:    mask_o = COL_W'(3);
            BLEN_8:    mask_o = COL_W'(7);
            BLEN_PAGE: begin
                if (ilv_i) begin
                    rsvd_o = 1'b1;
                end else begin
                    mask_o = ALL_ONES;
                    full_o = 1'b1;
                end
            end
            default:   rsvd_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/burst_beat_ctr.sv
// Module: beat counter and burst-active state.
// Assumes mask_i/full_i describe the latched burst. Priority is
// start > terminate > advance. A full-page burst never raises last.
module burst_beat_ctr #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             adv_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    output logic             valid_o,
    output logic [COL_W-1:0] beat_o,
    output logic             last_o
);
    // Purpose: flag the final beat of a fixed-length burst.
    always_comb begin
        last_o = valid_o && !full_i && (beat_o == mask_i);
    end

    // Purpose: track burst activity and the beat index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            beat_o  <= '0;
        end else if (start_i) begin
            valid_o <= 1'b1;
            beat_o  <= '0;
        end else if (valid_o) begin
            if (term_i) begin
                valid_o <= 1'b0;
            end else if (adv_i) begin
                if (last_o) begin
                    valid_o <= 1'b0;
                end else begin
                    beat_o <= beat_o + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
// Module: forms the column from start column, beat index and wrap mask.
// Bits under the mask take the linear or XOR offset; others keep the start.
// Assumes ilv_i is already forced to 0 for full-page bursts.
module burst_col_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] lin_off;
    logic [COL_W-1:0] xor_off;
    logic [COL_W-1:0] sel_off;

    // Purpose: build both candidate offsets and pick by ordering.
    always_comb begin
        lin_off = start_i + beat_i;
        xor_off = start_i ^ beat_i;
        sel_off = ilv_i ? xor_off : lin_off;
    end

    // Per-bit merge: masked bits wrap, unmasked bits stay fixed.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_i[b] ? sel_off[b] : start_i[b];
    end
endmodule

// File: rtl/burst_col_seq.sv
// Module: top of the burst column sequencer. It latches the burst setup
// on start and drives the beat counter and the column generator.
// Assumes start_i is a one-cycle strobe; the setup inputs are sampled
// only with it.
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  adv_i,
    input  logic                  term_i,
    input  logic [COL_W-1:0]      col_start_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  ilv_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  valid_o,
    output logic                  last_o,
    output logic                  len_err_o
);
    logic [COL_W-1:0]      start_q;
    logic [LEN_CODE_W-1:0] code_q;
    logic                  ilv_q;
    logic [COL_W-1:0]      mask;
    logic                  full;
    logic                  rsvd;
    logic [COL_W-1:0]      beat;

    // Purpose: capture the burst setup when a burst begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            code_q  <= '0;
            ilv_q   <= 1'b0;
        end else if (start_i) begin
            start_q <= col_start_i;
            code_q  <= len_code_i;
            ilv_q   <= ilv_i;
        end
    end

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i (code_q),
        .ilv_i  (ilv_q),
        .mask_o (mask),
        .full_o (full),
        .rsvd_o (rsvd)
    );

    burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .adv_i   (adv_i),
        .term_i  (term_i),
        .mask_i  (mask),
        .full_i  (full),
        .valid_o (valid_o),
        .beat_o  (beat),
        .last_o  (last_o)
    );

    burst_col_gen #(.COL_W(COL_W)) u_gen (
        .start_i (start_q),
        .beat_i  (beat),
        .mask_i  (mask),
        .ilv_i   (ilv_q && !full),
        .col_o   (col_o)
    );

    // Purpose: report a reserved code only while its burst is live.
    always_comb begin
        len_err_o = valid_o && rsvd;
    end
endmodule

// File: rtl/burst_col_seq_chk.sv
// Module: assertion checker bound to burst_col_seq. It observes the
// ports only.
module burst_col_seq_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             adv_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             len_err_o
);
    a_r2_start_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);

    a_r3_last_adv_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && adv_i && !start_i && !term_i) |=> !valid_o);

    a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    a_r8_term_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && term_i && !start_i) |=> !valid_o);

    a_r10_err_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> (valid_o && last_o));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !adv_i && !term_i && !start_i) |=> (valid_o && $stable(col_o)));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .adv_i     (adv_i),
    .term_i    (term_i),
    .col_o     (col_o),
    .valid_o   (valid_o),
    .last_o    (last_o),
    .len_err_o (len_err_o)
);

// File: tb/burst_col_seq_bench.sv
// Bench: drives bursts and compares the outputs every cycle against a
// behavioural reference model written with integers.
module burst_col_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;
    localparam int NCOL       = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             adv_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_start_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             ilv_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;
    logic             len_err_o;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // reference model state
    bit m_valid = 0;
    int m_beat = 0;
    int m_start = 0;
    int m_len = 1;
    bit m_full = 0;
    bit m_err = 0;
    bit m_ilv = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .adv_i       (adv_i),
        .term_i      (term_i),
        .col_start_i (col_start_i),
        .len_code_i  (len_code_i),
        .ilv_i       (ilv_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o),
        .len_err_o   (len_err_o)
    );

    function automatic bit ref_last();
        return m_valid && !m_full && (m_beat == m_len - 1);
    endfunction

    function automatic int ref_col();
        int base;
        int off;
        if (m_full) return (m_start + m_beat) % NCOL;
        base = (m_start / m_len) * m_len;
        if (m_ilv) off = (m_start % m_len) ^ m_beat;
        else       off = ((m_start % m_len) + m_beat) % m_len;
        return base + off;
    endfunction

    // reference model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0;
            m_beat  = 0;
            m_err   = 0;
        end else if (start_i) begin
            m_valid = 1;
            m_beat  = 0;
            m_start = int'(col_start_i);
            m_ilv   = ilv_i;
            m_full  = 0;
            m_err   = 0;
            case (len_code_i)
                3'd0: m_len = 1;
                3'd1: m_len = 2;
                3'd2: m_len = 4;
                3'd3: m_len = 8;
                3'd7: begin
                    if (ilv_i) begin m_len = 1; m_err = 1; end
                    else begin m_len = NCOL; m_full = 1; end
                end
                default: begin m_len = 1; m_err = 1; end
            endcase
        end else if (m_valid) begin
            if (term_i) m_valid = 0;
            else if (adv_i) begin
                if (ref_last()) m_valid = 0;
                else m_beat = m_beat + 1;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // comparison on every falling edge once reset has been applied
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "valid_o", int'(valid_o), int'(m_valid));
            check("R6", "last_o", int'(last_o), int'(ref_last()));
            check("R10", "len_err_o", int'(len_err_o), int'(m_valid && m_err));
            if (m_valid) check(cur_req, "col_o", int'(col_o), ref_col());
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // one burst: start pulse, then nadv cycles with advance gaps every gap-th cycle
    task automatic burst(input int s, input int code, input bit il, input int ncyc,
                         input int gap, input string req);
        cur_req     = req;
        col_start_i = COL_W'(s);
        len_code_i  = 3'(code);
        ilv_i       = il;
        start_i     = 1'b1;
        step();
        start_i = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            adv_i = (gap == 0) || ((k % gap) != 0);
            ilv_i = ~ilv_i;
            step();
        end
        adv_i = 1'b0;
        step();
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step(); step();
        // R1: reset state seen at the ports
        check("R1", "valid_o", int'(valid_o), 0);
        check("R1", "last_o", int'(last_o), 0);
        check("R1", "len_err_o", int'(len_err_o), 0);
        rst_n = 1'b1;
        step();
        burst(8'h45, 0, 0, 3, 0, "R2");
        burst(8'h33, 0, 1, 3, 0, "R9");
        burst(8'h13, 1, 0, 4, 0, "R3");
        burst(8'h26, 2, 0, 6, 0, "R4");
        burst(8'hFD, 3, 0, 10, 0, "R4");
        burst(8'h40, 3, 0, 10, 0, "R3");
        burst(8'h85, 3, 1, 10, 0, "R5");
        burst(8'h12, 2, 1, 6, 0, "R5");
        burst(8'h6B, 3, 0, 20, 3, "R11");
        burst(8'h5A, 3, 1, 20, 2, "R11");
        burst(8'hF0, 7, 0, 300, 0, "R7");
        cur_req = "R8";
        term_i = 1'b1; step(); term_i = 1'b0; step();
        burst(8'h22, 3, 0, 2, 0, "R8");
        burst(8'h22, 3, 0, 0, 0, "R8");
        term_i = 1'b1; step(); term_i = 1'b0; step();
        burst(8'h77, 4, 0, 2, 0, "R10");
        burst(8'h78, 5, 1, 2, 0, "R10");
        burst(8'h79, 6, 0, 2, 0, "R10");
        burst(8'h7A, 7, 1, 2, 0, "R10");
        // R12: restart in the middle of a burst
        cur_req = "R12";
        col_start_i = 8'h31; len_code_i = 3'd3; ilv_i = 1'b0; start_i = 1'b1;
        step(); start_i = 1'b0; adv_i = 1'b1; step(); step(); step();
        col_start_i = 8'hC6; len_code_i = 3'd2; ilv_i = 1'b1; start_i = 1'b1;
        step(); start_i = 1'b0;
        for (int k = 0; k < 6; k++) step();
        adv_i = 1'b0;
        step();
        // R1: reset in the middle of a burst
        burst(8'h10, 3, 0, 2, 0, "R1");
        col_start_i = 8'h10; start_i = 1'b1; step(); start_i = 1'b0; step();
        rst_n = 1'b0; step(); rst_n = 1'b1; #1;
        check("R1", "valid_o after reset", int'(valid_o), 0);
        check("R1", "len_err_o after reset", int'(len_err_o), 0);
        step(); step();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule